// File: doc/BRIEF.md
# Serial Character Transmitter with Clear-to-Send Gating

This block turns parallel characters into asynchronous serial frames. Software places a character in a single holding register. When the line is free and the peripheral grants permission through an active-low clear-to-send input, the character moves into a shift register. It then leaves on the serial output as a start bit, five to eight data bits sent least significant first, an optional parity bit, and one or two stop bits. Every bit lasts one pulse of the transmit clock enable `txTick`, which an external baud generator supplies. The block has no bus decoding of its own. The write strobe, the data and the configuration levels come from the register interface that surrounds it.

Two flags report the state of the storage. `holdEmpty` shows that the holding register can take a new character. `shiftEmpty` shows that no frame is in progress. When both are set, `bothEmpty` is raised, so the request to transmit can be withdrawn. A character that waits in the holding register follows the previous frame with no idle bit between them. A break control holds the line low while the frames keep running underneath.

Top module: `uart_tx_cts`

## Requirements
- R1: After reset `txOut` is 1, `holdEmpty`, `shiftEmpty` and `bothEmpty` are 1, and `overrun` is 0.
- R2: A character moves from the holding register to the shift register only in a cycle with `txTick` = 1 and `ctsN` = 0, and only when the holding write was made in an earlier cycle. A write in the same cycle as the tick waits for a later tick. While `ctsN` = 1 no transfer happens, and `holdEmpty` stays 0.
- R3: The frame is one start bit (0), then the data bits least significant first, then parity if enabled, then the stop bits (1). Each bit lasts from one `txTick` cycle to the next. The start bit appears on `txOut` in the cycle after the tick that loads the shift register.
- R4: The word length is 5 + `lenSel` (`lenSel` = 0 gives 5 bits, 3 gives 8). Data bits above the word length are not sent.
- R5: With `parEn` = 1 a parity bit follows the data. With `parOdd` = 0 the number of ones over the data and parity bits is even; with `parOdd` = 1 it is odd.
- R6: `twoStop` = 0 sends one stop bit and `twoStop` = 1 sends two.
- R7: `holdEmpty` rises on the first `txTick` after the tick that loaded the shift register, never on the load tick itself.
- R8: If a character is waiting and `ctsN` = 0, its start bit follows the last stop bit of the previous frame on the very next tick, with no idle bit.
- R9: `bothEmpty` is 1 exactly when `holdEmpty` and `shiftEmpty` are both 1. The line is then high unless break is on.
- R10: While `breakEn` = 1, `txOut` is 0. The frame keeps shifting, so bits after the break is released and the end of the frame keep their schedule.
- R11: A holding write while a character still waits in the holding register replaces that character and sets `overrun`. `overrun` stays set until reset.
- R12: The word length, parity and stop settings are captured when a frame loads. Changes made during a frame affect only later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| txTick | input | 1 | Transmit clock enable, one pulse per bit time |
| wrStb | input | 1 | Holding register write strobe (one cycle) |
| wrData | input | 8 | Character to write |
| lenSel | input | 2 | Word length select, length = 5 + lenSel |
| parEn | input | 1 | Parity bit enable |
| parOdd | input | 1 | 1 = odd parity, 0 = even parity |
| twoStop | input | 1 | 1 = two stop bits, 0 = one |
| breakEn | input | 1 | Forces the serial line low |
| ctsN | input | 1 | Clear to send, active low |
| txOut | output | 1 | Serial data output, idle high |
| holdEmpty | output | 1 | Holding register can accept a character |
| shiftEmpty | output | 1 | No frame in progress |
| bothEmpty | output | 1 | Holding and shift registers both empty |
| overrun | output | 1 | Sticky: a waiting character was overwritten |

## Verification
Two events can fall in the same cycle: the tick that ends the last stop bit, and the transfer of a waiting character into the shift register. The bench writes a second character while the first frame is still running. It then counts ticks against the frame length it computes itself and requires a start bit in the sample right after the last stop bit, with `shiftEmpty` still low. A second collision, a holding write in the same cycle as a tick, is driven directly. It must leave the shift register empty until the next tick.

// File: rtl/txu_pkg.sv
package txu_pkg;
  // Width of the word length select field
  localparam int LEN_W = 2;

  // Strobes from control to datapath, at most one high per cycle
  typedef struct packed {
    logic load;   // copy holding register into shift register, drive start bit
    logic shift;  // put next frame bit on the line
    logic idle;   // frame over and nothing to follow: line goes high
  } txStrb_t;
endpackage

// File: rtl/txu_ctrl.sv
module txu_ctrl
  import txu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             txTick,
  input  logic             wrStb,
  input  logic             ctsN,
  input  logic [LEN_W-1:0] lenSel,
  input  logic             parEn,
  input  logic             twoStop,
  output txStrb_t          strb,
  output logic             holdEmpty,
  output logic             shiftEmpty,
  output logic             overrun
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int CNT_W   = $clog2(FRAME_W + 2);

  typedef enum logic [1:0] {
    HOLD_EMPTY,
    HOLD_FULL,
    HOLD_XFER   // copied out, empty flag not yet raised
  } holdSt_t;

  holdSt_t          holdSt;
  logic             busy;
  logic [CNT_W-1:0] remain;
  logic [CNT_W-1:0] frameLen;
  logic             lastBit;
  logic             canLoad;

  // start + (DATA_W-3+lenSel) data + parity + stops
  assign frameLen = CNT_W'(DATA_W - 1) + CNT_W'(lenSel) + CNT_W'(parEn) + CNT_W'(twoStop);

  assign lastBit = busy && (remain == '0);
  assign canLoad = txTick && (holdSt == HOLD_FULL) && !ctsN && (!busy || lastBit);

  always_comb begin
    strb.load  = canLoad;
    strb.shift = txTick && busy && (remain != '0);
    strb.idle  = txTick && lastBit && !canLoad;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      remain <= '0;
    end else if (strb.load) begin
      busy   <= 1'b1;
      remain <= frameLen - CNT_W'(1);
    end else if (strb.shift) begin
      remain <= remain - CNT_W'(1);
    end else if (strb.idle) begin
      busy <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdSt  <= HOLD_EMPTY;
      overrun <= 1'b0;
    end else begin
      if (wrStb) begin
        holdSt <= HOLD_FULL;
        if (holdSt == HOLD_FULL && !canLoad) overrun <= 1'b1;
      end else if (canLoad) begin
        holdSt <= HOLD_XFER;
      end else if (txTick && holdSt == HOLD_XFER) begin
        holdSt <= HOLD_EMPTY;
      end
    end
  end

  assign holdEmpty  = (holdSt == HOLD_EMPTY);
  assign shiftEmpty = !busy;

  // R7
  hold_empty_after_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(holdEmpty) |-> $past(txTick));

  // R11
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overrun |=> overrun);
endmodule

// File: rtl/txu_datapath.sv
module txu_datapath
  import txu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txTick,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LEN_W-1:0]  lenSel,
  input  logic              parEn,
  input  logic              parOdd,
  input  txStrb_t           strb,
  output logic              txLine
);
  localparam int FRAME_W = DATA_W + 3;
  localparam int MIN_W   = DATA_W - 3;

  logic [DATA_W-1:0]  holdReg;
  logic [FRAME_W-1:0] shReg;
  logic [FRAME_W-1:0] frame;

  always_ff @(posedge clk) begin
    if (!rstN) holdReg <= '0;
    else if (wrStb) holdReg <= wrData;
  end

  // Bits after the start bit, first to go at index 0; unused tail stays 1 (stop/fill)
  always_comb begin
    int   wordLen;
    logic par;
    wordLen = MIN_W + int'(lenSel);
    par     = parOdd;
    frame   = '1;
    for (int i = 0; i < DATA_W; i++) begin
      if (i < wordLen) begin
        frame[i] = holdReg[i];
        par      = par ^ holdReg[i];
      end
    end
    for (int i = 0; i <= DATA_W; i++) begin
      if (parEn && i == wordLen) frame[i] = par;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shReg  <= '1;
      txLine <= 1'b1;
    end else if (strb.load) begin
      shReg  <= frame;
      txLine <= 1'b0;
    end else if (strb.shift) begin
      txLine <= shReg[0];
      shReg  <= {1'b1, shReg[FRAME_W-1:1]};
    end else if (strb.idle) begin
      txLine <= 1'b1;
    end
  end

  // R3
  line_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(txLine) |-> $past(txTick));
endmodule

// File: rtl/uart_tx_cts.sv
module uart_tx_cts
  import txu_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              txTick,
  input  logic              wrStb,
  input  logic [DATA_W-1:0] wrData,
  input  logic [LEN_W-1:0]  lenSel,
  input  logic              parEn,
  input  logic              parOdd,
  input  logic              twoStop,
  input  logic              breakEn,
  input  logic              ctsN,
  output logic              txOut,
  output logic              holdEmpty,
  output logic              shiftEmpty,
  output logic              bothEmpty,
  output logic              overrun
);
  txStrb_t strb;
  logic    txLine;

  txu_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .txTick(txTick), .wrStb(wrStb), .ctsN(ctsN),
    .lenSel(lenSel), .parEn(parEn), .twoStop(twoStop), .strb(strb),
    .holdEmpty(holdEmpty), .shiftEmpty(shiftEmpty), .overrun(overrun)
  );

  txu_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .txTick(txTick), .wrStb(wrStb), .wrData(wrData),
    .lenSel(lenSel), .parEn(parEn), .parOdd(parOdd), .strb(strb), .txLine(txLine)
  );

  assign txOut     = txLine & ~breakEn;
  assign bothEmpty = holdEmpty & shiftEmpty;

  // R2
  load_needs_cts_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(shiftEmpty) |-> $past(!ctsN) && $past(txTick));

  // R9
  idle_line_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (bothEmpty && !breakEn) |-> txOut);
endmodule

// File: tb/sim_uart_tx_cts.sv
module sim_uart_tx_cts;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       txTick = 1'b0, wrStb = 1'b0;
  logic [7:0] wrData = '0;
  logic [1:0] lenSel = '0;
  logic       parEn = 1'b0, parOdd = 1'b0, twoStop = 1'b0, breakEn = 1'b0, ctsN = 1'b0;
  logic       txOut, holdEmpty, shiftEmpty, bothEmpty, overrun;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_tx_cts u0 (
    .clk(clk), .rstN(rstN), .txTick(txTick), .wrStb(wrStb), .wrData(wrData),
    .lenSel(lenSel), .parEn(parEn), .parOdd(parOdd), .twoStop(twoStop),
    .breakEn(breakEn), .ctsN(ctsN), .txOut(txOut), .holdEmpty(holdEmpty),
    .shiftEmpty(shiftEmpty), .bothEmpty(bothEmpty), .overrun(overrun)
  );

  // vector: [12:11] lenSel, [10] parEn, [9] parOdd, [8] twoStop, [7:0] data
  localparam logic [12:0] VECS [6] = '{
    {2'd3, 1'b1, 1'b0, 1'b0, 8'hA5},
    {2'd0, 1'b0, 1'b0, 1'b0, 8'hFF},
    {2'd1, 1'b1, 1'b1, 1'b1, 8'h3C},
    {2'd2, 1'b0, 1'b0, 1'b1, 8'h81},
    {2'd3, 1'b1, 1'b1, 1'b0, 8'h00},
    {2'd0, 1'b1, 1'b0, 1'b1, 8'hE6}
  };

  function automatic int expLen(logic [12:0] v);
    return 1 + (5 + int'(v[12:11])) + int'(v[10]) + (v[8] ? 2 : 1);
  endfunction

  function automatic logic expBit(logic [12:0] v, int k);
    int n, ones;
    n = 5 + int'(v[12:11]);
    ones = 0;
    for (int i = 0; i < n; i++) if (v[i]) ones++;
    if (k == 0) return 1'b0;
    if (k <= n) return v[k-1];
    if (v[10] && k == n + 1) return v[9] ? ((ones % 2) == 0) : ((ones % 2) == 1);
    return 1'b1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    txTick = 1'b1;
    @(negedge clk);
    txTick = 1'b0;
  endtask

  task automatic writeHold(input logic [7:0] d);
    wrStb = 1'b1; wrData = d;
    @(negedge clk);
    wrStb = 1'b0;
  endtask

  task automatic applyCfg(input logic [12:0] v);
    lenSel = v[12:11]; parEn = v[10]; parOdd = v[9]; twoStop = v[8];
  endtask

  task automatic doReset();
    rstN = 1'b0; txTick = 0; wrStb = 0; breakEn = 0; ctsN = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
  endtask

  // Holding register already written; runs all bits of the frame, no trailing tick
  task automatic runFrame(input logic [12:0] v, input string tag);
    int len, bad, firstAct, firstExp;
    len = expLen(v); bad = 0; firstAct = 0; firstExp = 0;
    for (int k = 0; k < len; k++) begin
      tick();
      if (k == 0) check(!holdEmpty, "R7 holdEmpty low on load tick", holdEmpty, 0);
      if (k == 1) check(holdEmpty, "R7 holdEmpty one tick after load", holdEmpty, 1);
      if (txOut !== expBit(v, k)) begin
        if (bad == 0) begin firstAct = k * 2 + txOut; firstExp = k * 2 + expBit(v, k); end
        bad++;
      end
    end
    check(bad == 0, tag, firstAct, firstExp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    doReset();
    @(negedge clk);
    // R1 reset state
    check(txOut && holdEmpty && shiftEmpty && bothEmpty && !overrun, "R1 reset state",
          {txOut, holdEmpty, shiftEmpty, bothEmpty, overrun}, 5'b11110);

    // Table walk: R3 R4 R5 R6 frames, R9 idle afterwards
    for (int i = 0; i < 6; i++) begin
      applyCfg(VECS[i]);
      writeHold(VECS[i][7:0]);
      runFrame(VECS[i], "R3 R4 R5 R6 frame bits");
      tick();
      check(txOut && bothEmpty && shiftEmpty, "R9 idle after frame",
            {txOut, bothEmpty, shiftEmpty}, 3'b111);
    end

    // R2: write in the same cycle as a tick does not load
    applyCfg(VECS[0]);
    wrStb = 1'b1; wrData = 8'h5A; txTick = 1'b1;
    @(negedge clk);
    wrStb = 1'b0; txTick = 1'b0;
    check(shiftEmpty && txOut, "R2 same-cycle write not loaded", {shiftEmpty, txOut}, 2'b11);
    check(!bothEmpty, "R9 bothEmpty low with holding full", bothEmpty, 0);
    runFrame({VECS[0][12:8], 8'h5A}, "R2 frame after later tick");
    tick();

    // R2: clear-to-send deasserted blocks the transfer
    ctsN = 1'b1;
    writeHold(8'h33);
    repeat (3) tick();
    check(shiftEmpty && !holdEmpty && txOut, "R2 ctsN high blocks",
          {shiftEmpty, holdEmpty, txOut}, 3'b101);
    ctsN = 1'b0;
    runFrame({VECS[0][12:8], 8'h33}, "R2 frame after ctsN low");
    tick();

    // R8: back-to-back frames, R12: config change mid frame
    begin
      logic [12:0] va, vb;
      int bad;
      va = {2'd3, 1'b0, 1'b0, 1'b0, 8'hC3};
      vb = {2'd3, 1'b0, 1'b0, 1'b0, 8'h96};
      applyCfg(va);
      writeHold(va[7:0]);
      tick();                      // load A
      lenSel = 2'd0; parEn = 1'b1; // R12 change after load
      tick();                      // bit 1, holdEmpty rises
      writeHold(vb[7:0]);
      lenSel = 2'd3; parEn = 1'b0;
      check(!bothEmpty, "R9 bothEmpty low during frame", bothEmpty, 0);
      bad = 0;
      for (int k = 2; k < expLen(va); k++) begin
        if (k == 3) lenSel = 2'd1;
        tick();
        if (txOut !== expBit(va, k)) bad++;
      end
      lenSel = 2'd3;
      check(bad == 0, "R12 frame keeps load-time config", bad, 0);
      tick();
      check(!txOut && !shiftEmpty, "R8 start follows last stop", {txOut, shiftEmpty}, 2'b00);
      bad = 0;
      for (int k = 1; k < expLen(vb); k++) begin
        tick();
        if (txOut !== expBit(vb, k)) bad++;
      end
      check(bad == 0, "R8 second frame bits", bad, 0);
      tick();
      check(shiftEmpty && txOut, "R8 line idle after second frame", {shiftEmpty, txOut}, 2'b11);
    end

    // R10: break holds line low while shifting continues
    begin
      logic [12:0] vc;
      int bad;
      vc = {2'd3, 1'b0, 1'b0, 1'b0, 8'hFF};
      applyCfg(vc);
      writeHold(vc[7:0]);
      bad = 0;
      for (int k = 0; k < expLen(vc); k++) begin
        breakEn = (k >= 2 && k <= 5);
        tick();
        if (txOut !== (breakEn ? 1'b0 : expBit(vc, k))) bad++;
      end
      breakEn = 1'b0;
      check(bad == 0, "R10 break forces low, bits resume", bad, 0);
      tick();
      check(shiftEmpty && txOut, "R10 frame ends on schedule", {shiftEmpty, txOut}, 2'b11);
      breakEn = 1'b1;
      @(negedge clk);
      check(!txOut, "R10 break on idle line", txOut, 0);
      breakEn = 1'b0;
    end

    // R11: overwrite of a waiting character
    doReset();
    applyCfg(VECS[3]);
    writeHold(8'h11);
    check(!overrun, "R11 no overrun on first write", overrun, 0);
    writeHold(8'h7E);
    check(overrun, "R11 overrun set", overrun, 1);
    runFrame({VECS[3][12:8], 8'h7E}, "R11 newest character sent");
    tick();
    check(overrun, "R11 overrun sticky", overrun, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule